// File: doc/BRIEF.md
# Serial Input Byte Packer

This block sits on the receive side of a time-slotted serial audio/data port. In each time slot it shifts one byte in from one of several serial data lines, chosen per slot. Per-slot control bits from a slot sequencer then decide what happens to that byte. It can be appended to a four-byte word buffer, to a separate four-byte feedback buffer, to both, or to neither. An explicit store command pushes the assembled word toward an input FIFO.

The word buffer is pushed only when a slot record asks for it, and never just because all four positions have been filled. The feedback buffer is always visible to the transmit side of the port, which can resend bytes from it. The FIFO itself is outside the block: the block drives a one-cycle write strobe with the word and watches a full flag. A word stored while the FIFO is full is lost, and a sticky flag records the loss.

The sequencer pulses `slot_start_i` with the first (most significant) bit of a slot. The control fields are sampled on the clock edge that takes in the last bit of that slot. The same design is used for two circuits that differ only in which line select code 0 picks. A parameter sets this choice.

Top module: `ser_byte_packer`

## Requirements
- R1: Select code 1 reads the byte from serial line 1, code 2 from line 2 and code 3 from line 3 (`sd_i[1]`, `sd_i[2]`, `sd_i[3]`).
- R2: Select code 0 reads from line 0 (`sd_i[0]`) when `ALT_PIN`=0 and from line 4 (`sd_i[4]`) when `ALT_PIN`=1.
- R3: A byte is made of the eight bits sampled on the rising edges from the `slot_start_i` edge onward, with the most significant bit first. The control fields take effect at the eighth of these edges.
- R4: With the word-load bit at 1, the byte is written into the next free position of the word buffer, filling positions 0, 1, 2, 3 in order. Position i occupies bits [8i+7:8i]. With the bit at 0, the word buffer and its position are left unchanged.
- R5: With the feedback-load bit at 1, the byte is written into the next free position of the feedback buffer. The position wraps from 3 to 0. `fb_word_o` shows the new content in the cycle after the slot's last edge.
- R6: With the store bit at 1 and the FIFO not full, `fifo_wr_o` is high for exactly one cycle, the cycle after the slot's last edge. `fifo_data_o` then carries the word buffer, including positions not rewritten since the last store.
- R7: When load and store fall in the same slot, the byte is placed first and the word that includes it is pushed. After any store the word fill position returns to 0.
- R8: Loading a fifth byte without a store wraps the word position from 3 to 0 and overwrites position 0.
- R9: A store while `fifo_full_i` is high writes nothing and sets `overflow_o`, which stays high until reset. The word position still returns to 0.
- R10: After reset both buffers are zero, both positions are 0, `fifo_wr_o` is low and `overflow_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all sampling on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_i | input | PIN_CNT | Serial data lines 0..4 |
| slot_start_i | input | 1 | High with the first bit of a slot |
| pin_sel_i | input | 2 | Serial line select code |
| ld_word_i | input | 1 | Append byte to word buffer |
| ld_fb_i | input | 1 | Append byte to feedback buffer |
| store_i | input | 1 | Push word buffer to FIFO |
| fifo_full_i | input | 1 | FIFO cannot accept a word |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | BYTE_W*LANES | Word written to FIFO |
| fb_word_o | output | BYTE_W*LANES | Feedback buffer contents |
| overflow_o | output | 1 | Sticky lost-word flag |

## Verification
The bench builds two copies of the block from the same stimulus, one with `ALT_PIN`=0 and one with `ALT_PIN`=1. Both keep the default byte width of eight and four lanes. Driving different bytes on lines 0 and 4 under select code 0 therefore shows the two circuit variants side by side. The default four-lane depth keeps feedback wrap, word-position wrap and the load-plus-store ordering reachable within a few slots.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  localparam int unsigned SBP_SEL_W = 2;

  // Line index chosen by a select code; code 0 depends on the circuit variant.
  function automatic int unsigned pin_index(input logic [SBP_SEL_W-1:0] sel,
                                            input bit alt);
    if (sel == '0) return alt ? 4 : 0;
    return int'(sel);
  endfunction

  // Next fill position of a packing buffer, wrapping after the last lane.
  function automatic int unsigned next_pos(input int unsigned pos,
                                           input int unsigned lanes);
    return (pos + 1 >= lanes) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/sbp_shifter.sv
module sbp_shifter #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PIN_CNT = 5,
  parameter bit          ALT_PIN = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PIN_CNT-1:0]           sd_i,
  input  logic                         slot_start_i,
  input  logic [sbp_pkg::SBP_SEL_W-1:0] pin_sel_i,
  output logic                         byte_done_o,
  output logic [BYTE_W-1:0]            byte_o
);
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              bit_in;
  int unsigned       pin;

  always_comb begin
    pin    = sbp_pkg::pin_index(pin_sel_i, ALT_PIN);
    bit_in = (pin < PIN_CNT) ? sd_i[pin] : 1'b0;
  end

  // The byte is complete on the edge that samples its last bit.
  assign byte_done_o = (cnt == LAST) && !slot_start_i;
  assign byte_o      = {shreg[BYTE_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else begin
      if (slot_start_i) begin
        cnt <= CNT_W'(1);
      end else if (cnt == LAST) begin
        cnt <= '0;
      end else if (cnt != '0) begin
        cnt <= cnt + CNT_W'(1);
      end
      if (slot_start_i || cnt != '0) begin
        shreg <= {shreg[BYTE_W-2:0], bit_in};
      end
    end
  end
endmodule

// File: rtl/sbp_pack_buf.sv
module sbp_pack_buf #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [BYTE_W-1:0]         byte_i,
  input  logic                      rewind_i,
  output logic [BYTE_W*LANES-1:0]   word_o,
  output logic [BYTE_W*LANES-1:0]   merged_o,
  output logic [$clog2(LANES)-1:0]  pos_o
);
  localparam int unsigned POS_W = $clog2(LANES);

  logic [POS_W-1:0] pos;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = wr_i && (pos == POS_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (hit) word_o[g*BYTE_W +: BYTE_W] <= byte_i;
    end
    // Word as it reads after this edge's write: used for same-slot pushes.
    assign merged_o[g*BYTE_W +: BYTE_W] = hit ? byte_i : word_o[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (rewind_i) pos <= '0;
    else if (wr_i)     pos <= POS_W'(sbp_pkg::next_pos(int'(pos), LANES));
  end

  assign pos_o = pos;
endmodule

// File: rtl/sbp_push.sv
module sbp_push #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              full_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] data_o,
  output logic              drop_o,
  output logic              overflow_o
);
  logic go;
  assign go     = req_i && !full_i;
  assign drop_o = req_i && full_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_o       <= 1'b0;
      data_o     <= '0;
      overflow_o <= 1'b0;
    end else begin
      wr_o <= go;
      if (go)     data_o     <= word_i;
      if (drop_o) overflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_byte_packer.sv
module ser_byte_packer #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned LANES   = 4,
  parameter int unsigned PIN_CNT = 5,
  parameter bit          ALT_PIN = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PIN_CNT-1:0]           sd_i,
  input  logic                         slot_start_i,
  input  logic [sbp_pkg::SBP_SEL_W-1:0] pin_sel_i,
  input  logic                         ld_word_i,
  input  logic                         ld_fb_i,
  input  logic                         store_i,
  input  logic                         fifo_full_i,
  output logic                         fifo_wr_o,
  output logic [BYTE_W*LANES-1:0]      fifo_data_o,
  output logic [BYTE_W*LANES-1:0]      fb_word_o,
  output logic                         overflow_o
);
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned POS_W  = $clog2(LANES);

  // Named internal events, also used by the bound checker.
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              word_wr, fb_wr, word_push, word_drop;
  logic [WORD_W-1:0] word_cur, word_merged, fb_merged;
  logic [POS_W-1:0]  dw_pos, fb_pos;

  assign word_wr   = byte_done && ld_word_i;
  assign fb_wr     = byte_done && ld_fb_i;
  assign word_push = byte_done && store_i;

  sbp_shifter #(.BYTE_W(BYTE_W), .PIN_CNT(PIN_CNT), .ALT_PIN(ALT_PIN)) u_shift (
    .clk(clk), .rst_n(rst_n), .sd_i(sd_i), .slot_start_i(slot_start_i),
    .pin_sel_i(pin_sel_i), .byte_done_o(byte_done), .byte_o(byte_val)
  );

  sbp_pack_buf #(.BYTE_W(BYTE_W), .LANES(LANES)) u_word (
    .clk(clk), .rst_n(rst_n), .wr_i(word_wr), .byte_i(byte_val),
    .rewind_i(word_push), .word_o(word_cur), .merged_o(word_merged), .pos_o(dw_pos)
  );

  sbp_pack_buf #(.BYTE_W(BYTE_W), .LANES(LANES)) u_fb (
    .clk(clk), .rst_n(rst_n), .wr_i(fb_wr), .byte_i(byte_val),
    .rewind_i(1'b0), .word_o(fb_word_o), .merged_o(fb_merged), .pos_o(fb_pos)
  );

  sbp_push #(.WORD_W(WORD_W)) u_push (
    .clk(clk), .rst_n(rst_n), .req_i(word_push), .word_i(word_merged),
    .full_i(fifo_full_i), .wr_o(fifo_wr_o), .data_o(fifo_data_o),
    .drop_o(word_drop), .overflow_o(overflow_o)
  );

  logic unused_ok;
  assign unused_ok = ^{word_cur, fb_merged, word_drop};
endmodule

// File: rtl/ser_byte_packer_chk.sv
module ser_byte_packer_chk #(
  parameter int unsigned POS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_done,
  input logic             ld_word_i,
  input logic             ld_fb_i,
  input logic             store_i,
  input logic             fifo_full_i,
  input logic             fifo_wr_o,
  input logic             overflow_o,
  input logic [POS_W-1:0] dw_pos,
  input logic [POS_W-1:0] fb_pos
);
  localparam logic [POS_W-1:0] PMAX = '1;

  a_r6_push_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |-> $past(byte_done && store_i && !fifo_full_i));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |=> !fifo_wr_o);

  a_r9_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && store_i && fifo_full_i) |=> (!fifo_wr_o && overflow_o));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  a_r7_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && store_i) |=> (dw_pos == '0));

  a_r4_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && (ld_word_i || store_i)) |=> $stable(dw_pos));

  a_r5_fb_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ld_fb_i && fb_pos == PMAX) |=> (fb_pos == '0));
endmodule

bind ser_byte_packer ser_byte_packer_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .ld_word_i(ld_word_i),
  .ld_fb_i(ld_fb_i), .store_i(store_i), .fifo_full_i(fifo_full_i),
  .fifo_wr_o(fifo_wr_o), .overflow_o(overflow_o), .dw_pos(dw_pos), .fb_pos(fb_pos)
);

// File: tb/ser_byte_packer_bench.sv
`timescale 1ns/100ps
module ser_byte_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sd = '0;
  logic        slot_start = 1'b0;
  logic [1:0]  sel = '0;
  logic        ld_word = 1'b0, ld_fb = 1'b0, store = 1'b0, full = 1'b0;
  logic        wr_a, wr_b, ovf_a, ovf_b;
  logic [31:0] data_a, data_b, fb_a, fb_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // captured after each slot
  logic        c_wr, c_wr_b, c_ovf;
  logic [31:0] c_data, c_data_b, c_fb;

  always #2.5 clk = ~clk;

  ser_byte_packer #(.ALT_PIN(1'b0)) u_ser_byte_packer (
    .clk(clk), .rst_n(rst_n), .sd_i(sd), .slot_start_i(slot_start), .pin_sel_i(sel),
    .ld_word_i(ld_word), .ld_fb_i(ld_fb), .store_i(store), .fifo_full_i(full),
    .fifo_wr_o(wr_a), .fifo_data_o(data_a), .fb_word_o(fb_a), .overflow_o(ovf_a)
  );

  ser_byte_packer #(.ALT_PIN(1'b1)) u_ser_byte_packer_alt (
    .clk(clk), .rst_n(rst_n), .sd_i(sd), .slot_start_i(slot_start), .pin_sel_i(sel),
    .ld_word_i(ld_word), .ld_fb_i(ld_fb), .store_i(store), .fifo_full_i(full),
    .fifo_wr_o(wr_b), .fifo_data_o(data_b), .fb_word_o(fb_b), .overflow_o(ovf_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One slot: b on the selected line, b2 on line 4 under code 0, ~b elsewhere.
  task automatic slot(input logic [7:0] b, input logic [7:0] b2, input logic [1:0] s,
                      input logic dw, input logic fb, input logic st, input logic fl);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      slot_start = (i == 7);
      sel = s; ld_word = dw; ld_fb = fb; store = st; full = fl;
      sd = {5{~b[i]}};
      if (s == 2'd0) begin sd[0] = b[i]; sd[4] = b2[i]; end
      else sd[s] = b[i];
    end
    @(negedge clk);
    slot_start = 1'b0; ld_word = 1'b0; ld_fb = 1'b0; store = 1'b0; full = 1'b0;
    c_wr = wr_a; c_data = data_a; c_fb = fb_a; c_ovf = ovf_a;
    c_wr_b = wr_b; c_data_b = data_b;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  b;
    logic [1:0]  s;
    logic        dw, fb, st, fl, push;
    logic [31:0] data, fbw;
    logic        ovf;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'hA1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        32'h0,        1'b0},
    '{8'hB2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        32'h000000B2, 1'b0},
    '{8'hC3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        32'h000000B2, 1'b0},
    '{8'hD4, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'hD4C3B2A1, 32'h0000D4B2, 1'b0},
    '{8'h55, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        32'h0055D4B2, 1'b0},
    '{8'h66, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'hD4C3B2A1, 32'h6655D4B2, 1'b0},
    '{8'h77, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        32'h6655D477, 1'b0},
    '{8'h88, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0,        32'h6655D477, 1'b1},
    '{8'h99, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'hD4C38899, 32'h6655D477, 1'b1}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 wr", {31'b0, wr_a}, 32'h0);
    chk("R10 ovf", {31'b0, ovf_a}, 32'h0);
    chk("R10 fb", fb_a, 32'h0);

    // Table walk: R1 R3 R4 R5 R6 R7 R9
    for (int k = 0; k < 9; k++) begin
      slot(VEC[k].b, 8'h00, VEC[k].s, VEC[k].dw, VEC[k].fb, VEC[k].st, VEC[k].fl);
      chk("R6/R9 push", {31'b0, c_wr}, {31'b0, VEC[k].push});
      if (VEC[k].push) chk("R1/R3/R4/R7 data", c_data, VEC[k].data);
      chk("R5 fb", c_fb, VEC[k].fbw);
      chk("R9 ovf", {31'b0, c_ovf}, {31'b0, VEC[k].ovf});
    end
    @(negedge clk);
    chk("R6 one cycle", {31'b0, wr_a}, 32'h0);

    // R8: fifth load wraps to position 0
    do_reset();
    slot(8'h11, 8'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    slot(8'h22, 8'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    slot(8'h33, 8'h0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    slot(8'h44, 8'h0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    slot(8'h56, 8'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 no push", {31'b0, c_wr}, 32'h0);
    slot(8'hEE, 8'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 push", {31'b0, c_wr}, 32'h1);
    chk("R8 data", c_data, 32'h44332256);
    chk("R4 fb untouched", c_fb, 32'h0);

    // R2: code 0 picks line 0 or line 4 by variant
    do_reset();
    slot(8'h5A, 8'hA5, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R2 line0 push", {31'b0, c_wr}, 32'h1);
    chk("R2 line0 data", c_data, 32'h0000005A);
    chk("R2 line4 push", {31'b0, c_wr_b}, 32'h1);
    chk("R2 line4 data", c_data_b, 32'h000000A5);

    // R9: overflow cleared only by reset
    slot(8'h01, 8'h0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 set", {31'b0, c_ovf}, 32'h1);
    do_reset();
    chk("R10 ovf cleared", {31'b0, ovf_a}, 32'h0);

    finish_run();
  end
endmodule